// File: doc/BRIEF.md
# Prescaled 64-bit Shared Timebase Counter

This block keeps one 64-bit up-counter that every processor core in a cluster reads as a common sense of time. A clock divider sets the counting rate. A programmed divide value N produces one increment every N+1 clocks while the run bit is set. The live count and a one-cycle step pulse go out on dedicated ports, so the per-core compare logic that sits beside this block can follow the count without making bus accesses.

Software reaches the block through a 32-bit register window that is 0x20 bytes wide. The count appears as two 32-bit words. A write to either word is accepted only while the counter is stopped, and it changes only the word that is addressed. The control word holds the shared run bit and the divide value. When that word is read, the result also carries the per-core bits of the core that made the request. The block does not store those bits: the caller supplies them on an input. Read data is returned in the cycle after the request.

Top module: `tbase_timer`

## Requirements
- R1: After reset the count is zero, the step pulse is low, and a control read with zero per-core bits returns zero.
- R2: While the run bit (control bit 0) is set and the divide field (control bits 15:8) holds N, the count rises by exactly one every N+1 clocks. The first increment lands N+1 clocks after the control write that started the counter.
- R3: While the run bit is clear, the count holds its value and the step pulse stays low.
- R4: With the counter stopped, a write to offset 0x00 loads count bits 31:0 and leaves bits 63:32 unchanged.
- R5: With the counter stopped, a write to offset 0x04 loads count bits 63:32 and leaves bits 31:0 unchanged.
- R6: A write to offset 0x00 or 0x04 while the run bit is set has no effect on the count.
- R7: A read of offset 0x08 returns the stored shared bits (bit 0 and bits 15:8) ORed with bits 3:1 of the per-core input. Any other written control bits are not stored.
- R8: A read of offset 0x00 or 0x04 returns the low or high word of the count as it stood in the request cycle, with the data valid one cycle later. A carry out of the low word reaches the high word.
- R9: A read of any other offset, or of an address whose bits 1:0 are not zero, returns zero. A write to such an address changes neither the count nor the control bits.
- R10: A control write that changes the divide value restarts the divider from zero, so the next increment comes N+1 clocks after that write.
- R11: The step output is high for exactly one cycle after each increment of the count, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the 0x20-byte window |
| bus_wdata | input | 32 | Write data |
| core_bank_ctrl | input | 32 | Per-core control bits of the requesting core (bits 3:1 used) |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| count_o | output | 64 | Live count |
| tick_o | output | 1 | One-cycle pulse following each increment |

## Verification
The bench sweeps the divide value across a small range and checks the count against floor(k/(N+1)) at every clock after the start. An off-by-one in the divider would drift away from this formula within the first period. The bench also checks the count after the stop, where an increment still due at the stopping edge has to be counted. A rate change in mid-period is checked next: a divider that does not restart would have to wrap through its whole range before the count rose again. Other checks load each word on its own and then write to a running counter, and these catch a merge that clobbers the other word or a write gate that has been left out. A read that straddles the carry from the low word into the high word shows whether the read port captures the count in the request cycle. Reads and writes to every unused offset, and to a misaligned address, catch decoding that is incomplete.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int PRESC_W  = 8;
    localparam int PRESC_LSB = 8;
    localparam int RUN_BIT  = 0;

    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;

    localparam logic [DATA_W-1:0] BANK_MASK = 32'h0000_000E;

    typedef struct packed {
        logic               run;
        logic [PRESC_W-1:0] presc;
    } shared_ctrl_t;
endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
    parameter int PRESC_W = tbase_pkg::PRESC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               restart_i,
    output logic               step_o
);
    typedef struct packed {
        logic [PRESC_W-1:0] div;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        step_o = run_i && (st_q.div == presc_i);
        if (!run_i || restart_i || step_o) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && presc_i != '0 && !restart_i) |=> !step_o);
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int DATA_W = tbase_pkg::DATA_W,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              step_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             tick;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (run_i) begin
            if (step_i) begin
                st_d.count = st_q.count + 1'b1;
                st_d.tick  = 1'b1;
            end
        end else if (wr_lo_i) begin
            st_d.count[DATA_W-1:0] = wdata_i;
        end else if (wr_hi_i) begin
            st_d.count[CNT_W-1:DATA_W] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign tick_o  = st_q.tick;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(count_o));

    // R4
    lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && wr_lo_i) |=>
        (count_o[DATA_W-1:0] == $past(wdata_i) &&
         count_o[CNT_W-1:DATA_W] == $past(count_o[CNT_W-1:DATA_W])));

    // R6
    running_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (wr_lo_i || wr_hi_i)) |=>
        (count_o == $past(count_o) + {{(CNT_W-1){1'b0}}, $past(step_i)}));
endmodule

// File: rtl/tbase_regif.sv
module tbase_regif #(
    parameter int DATA_W  = tbase_pkg::DATA_W,
    parameter int ADDR_W  = tbase_pkg::ADDR_W,
    parameter int PRESC_W = tbase_pkg::PRESC_W,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  core_bank_ctrl,
    input  logic [CNT_W-1:0]   count_i,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               run_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic               restart_o,
    output logic               wr_lo_o,
    output logic               wr_hi_o
);
    import tbase_pkg::*;

    typedef struct packed {
        shared_ctrl_t      ctrl;
        logic [DATA_W-1:0] rdata;
    } rif_state_t;

    rif_state_t st_d, st_q;

    logic              aligned, hit_lo, hit_hi, hit_ctrl, wr_ctrl;
    logic [DATA_W-1:0] shared_word;
    logic [PRESC_W-1:0] new_presc;

    always_comb begin
        aligned   = (bus_addr[1:0] == 2'b00);
        hit_lo    = aligned && (bus_addr == OFF_CNT_LO);
        hit_hi    = aligned && (bus_addr == OFF_CNT_HI);
        hit_ctrl  = aligned && (bus_addr == OFF_CTRL);
        wr_lo_o   = bus_valid && bus_write && hit_lo;
        wr_hi_o   = bus_valid && bus_write && hit_hi;
        wr_ctrl   = bus_valid && bus_write && hit_ctrl;
        new_presc = bus_wdata[PRESC_LSB +: PRESC_W];
        restart_o = wr_ctrl && (new_presc != st_q.ctrl.presc);

        shared_word = '0;
        shared_word[RUN_BIT] = st_q.ctrl.run;
        shared_word[PRESC_LSB +: PRESC_W] = st_q.ctrl.presc;

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.run   = bus_wdata[RUN_BIT];
            st_d.ctrl.presc = new_presc;
        end
        if (bus_valid && !bus_write) begin
            if (hit_lo)        st_d.rdata = count_i[DATA_W-1:0];
            else if (hit_hi)   st_d.rdata = count_i[CNT_W-1:DATA_W];
            else if (hit_ctrl) st_d.rdata = shared_word | (core_bank_ctrl & BANK_MASK);
            else               st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign run_o     = st_q.ctrl.run;
    assign presc_o   = st_q.ctrl.presc;

    // R9
    undefined_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !hit_lo && !hit_hi && !hit_ctrl) |=> (bus_rdata == '0));

    // R9
    undefined_write_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !hit_ctrl) |=> ($stable(run_o) && $stable(presc_o)));
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer #(
    parameter int DATA_W  = tbase_pkg::DATA_W,
    parameter int ADDR_W  = tbase_pkg::ADDR_W,
    parameter int PRESC_W = tbase_pkg::PRESC_W,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] core_bank_ctrl,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic              tick_o
);
    logic               run, restart, step, wr_lo, wr_hi;
    logic [PRESC_W-1:0] presc;

    tbase_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .core_bank_ctrl(core_bank_ctrl), .count_i(count_o),
        .bus_rdata(bus_rdata), .run_o(run), .presc_o(presc), .restart_o(restart),
        .wr_lo_o(wr_lo), .wr_hi_o(wr_hi)
    );

    tbase_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run_i(run), .presc_i(presc),
        .restart_i(restart), .step_o(step)
    );

    tbase_counter #(.DATA_W(DATA_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(step),
        .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(bus_wdata),
        .count_o(count_o), .tick_o(tick_o)
    );

    // R11
    tick_tracks_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (count_o != $past(count_o)));
endmodule

// File: tb/tbase_timer_bench.sv
module tbase_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] core_bank_ctrl = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_o;
    logic        tick_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tbase_timer u_tbase_timer (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .core_bank_ctrl(core_bank_ctrl),
        .bus_rdata(bus_rdata), .count_o(count_o), .tick_o(tick_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", count_o, 64'd0);
        chk("R1 tick", {63'd0, tick_o}, 64'd0);
        do_read(5'h08, rd);
        chk("R1 ctrl", {32'd0, rd}, 64'd0);

        // R2 / R11 / R3 rate sweep
        for (int n = 0; n < 6; n++) begin
            int m;
            int stop_cnt;
            m = 3 * (n + 1) + 1;
            do_write(5'h00, 32'd0);
            do_write(5'h04, 32'd0);
            do_write(5'h08, (n << 8) | 1);
            for (int k = 0; k <= m; k++) begin
                chk($sformatf("R2 count n=%0d k=%0d", n, k), count_o, 64'(k / (n + 1)));
                chk($sformatf("R11 tick n=%0d k=%0d", n, k), {63'd0, tick_o},
                    64'((k > 0 && k % (n + 1) == 0) ? 1 : 0));
                @(negedge clk);
            end
            do_write(5'h08, n << 8);
            stop_cnt = (m + 2) / (n + 1);
            chk($sformatf("R2 stop count n=%0d", n), count_o, 64'(stop_cnt));
            idle(5);
            chk($sformatf("R3 hold n=%0d", n), count_o, 64'(stop_cnt));
            chk($sformatf("R3 tick n=%0d", n), {63'd0, tick_o}, 64'd0);
        end

        // R4 / R5 half loads while stopped
        do_write(5'h00, 32'hDEAD_BEEF);
        chk("R4 lo load", count_o, {32'd0, 32'hDEAD_BEEF});
        do_write(5'h04, 32'h1234_5678);
        chk("R5 hi load", count_o, 64'h1234_5678_DEAD_BEEF);
        do_write(5'h00, 32'h0000_0001);
        chk("R4 hi kept", count_o, 64'h1234_5678_0000_0001);
        do_write(5'h04, 32'hCAFE_0000);
        chk("R5 lo kept", count_o, 64'hCAFE_0000_0000_0001);
        do_read(5'h00, rd);
        chk("R8 read lo stopped", {32'd0, rd}, 64'h0000_0001);
        do_read(5'h04, rd);
        chk("R8 read hi stopped", {32'd0, rd}, 64'hCAFE_0000);

        // R6 writes dropped while running
        do_write(5'h00, 32'd5);
        do_write(5'h04, 32'd0);
        do_write(5'h08, (200 << 8) | 1);
        do_write(5'h00, 32'hAAAA_AAAA);
        do_write(5'h04, 32'h5555_5555);
        chk("R6 running write dropped", count_o, 64'd5);
        do_write(5'h08, 32'd0);
        chk("R6 count after stop", count_o, 64'd5);

        // R8 live read across the word carry
        do_write(5'h00, 32'hFFFF_FFFE);
        do_write(5'h04, 32'd7);
        do_write(5'h08, 32'h0000_0001);
        do_read(5'h04, rd);
        chk("R8 live hi", {32'd0, rd}, 64'd7);
        chk("R8 after first step", count_o, 64'h7_FFFF_FFFF);
        do_read(5'h00, rd);
        chk("R8 live lo", {32'd0, rd}, 64'hFFFF_FFFF);
        chk("R8 carry into hi", count_o, 64'h8_0000_0000);
        chk("R11 tick on carry", {63'd0, tick_o}, 64'd1);
        do_write(5'h08, 32'd0);

        // R7 control read-back
        do_write(5'h08, 32'hFFFF_AB0E);
        core_bank_ctrl = 32'd0;
        do_read(5'h08, rd);
        chk("R7 shared only", {32'd0, rd}, 64'h0000_AB00);
        core_bank_ctrl = 32'h0000_000A;
        do_read(5'h08, rd);
        chk("R7 banked or", {32'd0, rd}, 64'h0000_AB0A);
        core_bank_ctrl = 32'hFFFF_FFFF;
        do_read(5'h08, rd);
        chk("R7 banked masked", {32'd0, rd}, 64'h0000_AB0E);
        core_bank_ctrl = 32'd0;

        // R9 undefined offsets
        held = count_o;
        for (int a = 12; a < 32; a += 4) begin
            do_write(5'(a), 32'hFFFF_FFFF);
            do_read(5'(a), rd);
            chk($sformatf("R9 read off %0h", a), {32'd0, rd}, 64'd0);
        end
        do_write(5'h01, 32'hFFFF_FFFF);
        do_write(5'h09, 32'hFFFF_FFFF);
        do_read(5'h01, rd);
        chk("R9 misaligned read", {32'd0, rd}, 64'd0);
        idle(3);
        chk("R9 count untouched", count_o, held);
        do_read(5'h08, rd);
        chk("R9 ctrl untouched", {32'd0, rd}, 64'h0000_AB00);

        // R10 divider restart on rate change
        do_write(5'h00, 32'd0);
        do_write(5'h04, 32'd0);
        do_write(5'h08, (3 << 8) | 1);
        idle(2);
        do_write(5'h08, (1 << 8) | 1);
        for (int j = 0; j <= 6; j++) begin
            chk($sformatf("R10 count j=%0d", j), count_o, 64'(j / 2));
            @(negedge clk);
        end
        do_write(5'h08, 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule